// File: doc/BRIEF.md
# GPIO Port Data Register

This block is the data register of a 12-pin general-purpose I/O port. The twelve port bits are packed into a 16-bit word with four reserved positions that always read as one. A separate direction register decides, pin by pin, whether a pin is driven. For a driven pin, the stored bit appears on the pin and is also what a read returns. For an undriven pin, a read returns the synchronized pin level. A write still lands in the stored bit, but it has no effect on the pin.

The register sits on a simple synchronous register bus. It accepts byte or halfword accesses, and every access completes in two cycles with an acknowledge pulse in the second cycle. An active-low output-disable input releases a contiguous group of pins (port bits 6 to 10) to high impedance regardless of the stored data. The register clears on the external power-on reset and while hardware standby is asserted. A watchdog reset only aborts the bus logic and leaves the stored data intact. No input is needed for sleep or software standby, because the register simply holds its contents.

Top module: `gpio_pdr`

## Requirements
- R1: After the external reset `rst_n` is released, every port bit is 0, `pin_out` is 0 and a halfword read returns 0xC0C0.
- R2: Port bit i sits at word bit i for i in 0..5 and at word bit i+2 for i in 6..11. Word bits 15, 14, 7 and 6 always read as 1, and writes to them are ignored.
- R3: An access is accepted when `bus_sel` is high, `bus_rd` or `bus_wr` is high and `bus_addr[ADDR_W-1:1]` equals `REG_ADDR[ADDR_W-1:1]` at a clock edge while no access is in progress. `bus_ack` is then high for exactly the next cycle and low otherwise. `bus_rdata` carries the read word in that cycle and is 0 in every other cycle. A non-matching address gets no acknowledge and changes nothing.
- R4: `bus_size`=1 selects a halfword access that writes all port bits. `bus_size`=0 selects a byte access that writes only word bits 15:8 when `bus_addr[0]`=0 and only word bits 7:0 when `bus_addr[0]`=1. The write takes effect at the edge that ends the acknowledge cycle.
- R5: For a pin with `pin_dir`=1, `pin_out` carries the stored bit and a read returns the stored bit.
- R6: For a pin with `pin_dir`=0, a read returns the pin level delayed by `SYNC_STAGES` flops and `pin_oe` is 0. A write still updates the stored bit, which becomes visible once the pin is switched to output.
- R7: While `out_dis_n` is 0, `pin_oe` is 0 for port bits `DIS_LO`..`DIS_HI` (6..10 by default), and the other pins are unaffected.
- R8: While `hw_standby` is 1, the stored bits clear to 0 from the next edge and no access is accepted.
- R9: A low `wdt_rst_n` aborts the bus logic but leaves the stored port bits and `pin_out` unchanged.
- R10: Outside the `out_dis_n` gating, `pin_oe` equals `pin_dir` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External power-on reset, active low |
| wdt_rst_n | input | 1 | Watchdog reset, active low, bus logic only |
| hw_standby | input | 1 | Hardware standby, clears the register |
| bus_sel | input | 1 | Bus select |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 1 | 1 = halfword, 0 = byte |
| bus_wdata | input | 16 | Write data, byte lanes in place |
| bus_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Access complete, second cycle |
| pin_dir | input | 12 | Per-pin direction, 1 = output |
| pin_in | input | 12 | Pin levels, asynchronous |
| out_dis_n | input | 1 | Output disable for bits 6..10, active low |
| pin_out | output | 12 | Pin output values |
| pin_oe | output | 12 | Pin output enables |

## Verification
The bench uses the default build: an 8-bit address with the register at 0x86, a two-stage synchronizer and the disable group at bits 6..10. With these values both byte lanes, the split mapping around the reserved holes and both edges of the disable group are reachable. Random address flips hit the non-matching decode. Random direction and pin patterns cover mixed read sources within one word. Directed cases cover standby clearing, the watchdog leaving data intact and writes to pins that are inputs.

// File: rtl/gpio_pdr_pkg.sv
package gpio_pdr_pkg;

  localparam int REG_W   = 16;
  localparam int NPORT   = 12;
  localparam int LOW_RUN = 6;   // port bits below this map 1:1
  localparam int HOLE    = 2;   // reserved positions skipped above them
  localparam int LANE_W  = 8;
  localparam int NLANES  = REG_W / LANE_W;

  typedef enum logic {ST_IDLE, ST_ACK} bus_st_e;

  function automatic int port2reg(input int i);
    return (i < LOW_RUN) ? i : i + HOLE;
  endfunction

  function automatic logic [REG_W-1:0] port_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NPORT; i++) m[port2reg(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] RSV_MASK = ~port_mask();

endpackage

// File: rtl/gpio_pdr_rstsync.sv
module gpio_pdr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pdr_sync.sv
module gpio_pdr_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pdr_busif.sv
module gpio_pdr_busif
  import gpio_pdr_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h86
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_standby,
  input  logic               bus_sel,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_size,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic               ack,
  output logic               wr_commit,
  output logic [NLANES-1:0]  lane_en,
  output logic [REG_W-1:0]   wdata_q
);
  bus_st_e             st_q, st_d;
  logic                wr_q, wr_d;
  logic [NLANES-1:0]   lane_q, lane_d;
  logic [REG_W-1:0]    wd_d;
  logic                hit, accept;
  logic [NLANES-1:0]   lane_sel;

  always_comb begin
    hit    = bus_sel && (bus_wr || bus_rd) &&
             (bus_addr[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]);
    accept = hit && !hw_standby && (st_q == ST_IDLE);
    // byte at even address takes the upper lane
    if (bus_size)      lane_sel = '1;
    else if (bus_addr[0]) lane_sel = 2'b01;
    else               lane_sel = 2'b10;
  end

  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    lane_d = lane_q;
    wd_d   = wdata_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_ACK;
        wr_d   = bus_wr;
        lane_d = lane_sel;
        wd_d   = bus_wdata;
      end
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      lane_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      wr_q    <= wr_d;
      lane_q  <= lane_d;
      wdata_q <= wd_d;
    end
  end

  assign ack       = (st_q == ST_ACK);
  assign wr_commit = (st_q == ST_ACK) && wr_q;
  assign lane_en   = lane_q;
endmodule

// File: rtl/gpio_pdr_store.sv
module gpio_pdr_store
  import gpio_pdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_standby,
  input  logic              wr_commit,
  input  logic [NLANES-1:0] lane_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [NPORT-1:0]  port_q
);
  logic [NPORT-1:0] port_d;
  logic             port_en;

  always_comb begin
    port_d  = port_q;
    port_en = hw_standby || wr_commit;
    if (hw_standby) begin
      port_d = '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (lane_en[port2reg(i) / LANE_W]) port_d[i] = wdata[port2reg(i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (port_en) port_q <= port_d;
  end
endmodule

// File: rtl/gpio_pdr.sv
module gpio_pdr
  import gpio_pdr_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 'h86,
  parameter int                SYNC_STAGES = 2,
  parameter int                DIS_LO      = 6,
  parameter int                DIS_HI      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst_n,
  input  logic              hw_standby,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ack,
  input  logic [11:0]       pin_dir,
  input  logic [11:0]       pin_in,
  input  logic              out_dis_n,
  output logic [11:0]       pin_out,
  output logic [11:0]       pin_oe
);
  logic              por_rst_n;
  logic              bus_rst_n;
  logic              ack;
  logic              wr_commit;
  logic [NLANES-1:0] lane_en;
  logic [REG_W-1:0]  wdata_q;
  logic [NPORT-1:0]  port_q;
  logic [NPORT-1:0]  pin_s;
  logic [REG_W-1:0]  rd_word;

  gpio_pdr_rstsync #(.STAGES(2)) u_por_rs (
    .clk(clk), .arst_n(rst_n), .srst_n(por_rst_n));

  gpio_pdr_rstsync #(.STAGES(2)) u_bus_rs (
    .clk(clk), .arst_n(rst_n & wdt_rst_n), .srst_n(bus_rst_n));

  gpio_pdr_busif #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
    .clk(clk), .rst_n(bus_rst_n), .hw_standby(hw_standby),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .ack(ack),
    .wr_commit(wr_commit), .lane_en(lane_en), .wdata_q(wdata_q));

  gpio_pdr_store u_store (
    .clk(clk), .rst_n(por_rst_n), .hw_standby(hw_standby),
    .wr_commit(wr_commit), .lane_en(lane_en), .wdata(wdata_q),
    .port_q(port_q));

  gpio_pdr_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_rst_n), .async_in(pin_in), .sync_out(pin_s));

  always_comb begin
    rd_word = RSV_MASK;
    for (int i = 0; i < NPORT; i++)
      rd_word[port2reg(i)] = pin_dir[i] ? port_q[i] : pin_s[i];
  end

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_pin
      if (i >= DIS_LO && i <= DIS_HI) begin : g_gated
        assign pin_oe[i] = pin_dir[i] & out_dis_n;
      end else begin : g_free
        assign pin_oe[i] = pin_dir[i];
      end
    end
  endgenerate

  assign pin_out   = port_q;
  assign bus_ack   = ack;
  assign bus_rdata = ack ? rd_word : '0;
endmodule

// File: rtl/gpio_pdr_chk.sv
module gpio_pdr_chk
  import gpio_pdr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIS_LO = 6,
  parameter int DIS_HI = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_rst_n,
  input logic              hw_standby,
  input logic              bus_sel,
  input logic [15:0]       bus_rdata,
  input logic              bus_ack,
  input logic [11:0]       pin_dir,
  input logic              out_dis_n,
  input logic [11:0]       pin_out,
  input logic [11:0]       pin_oe
);
  function automatic logic [11:0] dis_group();
    logic [11:0] m;
    m = '0;
    for (int i = DIS_LO; i <= DIS_HI; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [11:0] DIS_MASK = dis_group();

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_ack_after_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_sel));

  assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));

  assert_reserved_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> ((bus_rdata & RSV_MASK) == RSV_MASK));

  assert_disable_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dis_n |-> ((pin_oe & DIS_MASK) == '0));

  assert_oe_within_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~pin_dir) == '0);

  assert_standby_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (pin_out == '0));

  assert_wdt_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_rst_n && !hw_standby) |=> $stable(pin_out));
endmodule

bind gpio_pdr gpio_pdr_chk #(.ADDR_W(ADDR_W), .DIS_LO(DIS_LO), .DIS_HI(DIS_HI)) u_chk (.*);

// File: tb/sim_gpio_pdr.sv
`timescale 1ns/1ps
module sim_gpio_pdr;
  localparam logic [7:0] REG = 8'h86;

  logic        clk = 1'b0;
  logic        rst_n, wdt_rst_n, hw_standby;
  logic        bus_sel, bus_wr, bus_rd, bus_size;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ack;
  logic [11:0] pin_dir, pin_in, pin_out, pin_oe;
  logic        out_dis_n;

  int errors = 0;
  int checks = 0;
  logic [11:0] model;

  always #10 clk = ~clk;

  gpio_pdr u0 (.*);

  function automatic int bit_pos(input int i);
    if (i < 6) return i;
    return i + 2;
  endfunction

  function automatic logic [15:0] exp_word(input logic [11:0] dir,
                                           input logic [11:0] pins,
                                           input logic [11:0] dat);
    logic [15:0] w;
    w = 16'hC0C0;
    for (int i = 0; i < 12; i++) w[bit_pos(i)] = dir[i] ? dat[i] : pins[i];
    return w;
  endfunction

  function automatic logic [11:0] exp_oe(input logic [11:0] dir, input logic dis_n);
    logic [11:0] o;
    o = dir;
    if (!dis_n) o[10:6] = 5'b0;
    return o;
  endfunction

  function automatic logic [11:0] apply_wr(input logic [11:0] dat, input logic sz,
                                           input logic a0, input logic [15:0] wd);
    logic [11:0] d;
    d = dat;
    for (int i = 0; i < 12; i++) begin
      if (sz || ((bit_pos(i) >= 8) == !a0)) d[i] = wd[bit_pos(i)];
    end
    return d;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic sz, input logic [7:0] addr,
                        input logic [15:0] wd, input bit hit);
    logic [15:0] rd;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_rd = !wr; bus_size = sz;
    bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    chk("R3 ack", {15'b0, bus_ack}, {15'b0, hit});
    rd = bus_rdata;
    if (hit && !wr) chk("R5/R6 rdata", rd, exp_word(pin_dir, pin_in, model));
    if (!hit) chk("R3 rdata idle", rd, 16'h0);
    @(negedge clk);
    chk("R3 ack once", {15'b0, bus_ack}, 16'h0);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    if (hit && wr) model = apply_wr(model, sz, addr[0], wd);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [11:0] held;
    void'($urandom(32'hC0DE));
    rst_n = 1'b0; wdt_rst_n = 1'b1; hw_standby = 1'b0;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_size = 0; bus_addr = '0; bus_wdata = '0;
    pin_dir = 12'hFFF; pin_in = '0; out_dis_n = 1'b1;
    model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", {4'b0, pin_out}, 16'h0);
    chk("R3 idle ack", {15'b0, bus_ack}, 16'h0);
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);

    // R2 reserved ignore writes, R5 output path
    access(1'b1, 1'b1, REG, 16'hFFFF, 1'b1);
    chk("R5 pin_out all", {4'b0, pin_out}, 16'h0FFF);
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);
    access(1'b1, 1'b1, REG, 16'h0000, 1'b1);
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);

    // R4 byte lanes
    access(1'b1, 1'b0, REG, 16'h2A55, 1'b1);
    chk("R4 upper lane", {4'b0, pin_out}, {4'b0, model});
    access(1'b1, 1'b0, REG | 8'h01, 16'hFF15, 1'b1);
    chk("R4 lower lane", {4'b0, pin_out}, {4'b0, model});
    access(1'b0, 1'b0, REG | 8'h01, 16'h0, 1'b1);

    // R3 mismatched address changes nothing
    access(1'b1, 1'b1, REG ^ 8'h10, 16'hFFFF, 1'b0);
    chk("R3 no-hit write", {4'b0, pin_out}, {4'b0, model});

    // R6 input direction
    pin_dir = 12'h000; pin_in = 12'hA5A;
    settle();
    chk("R6 oe off", {4'b0, pin_oe}, 16'h0);
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);
    access(1'b1, 1'b1, REG, 16'h0F0F, 1'b1);
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);
    pin_dir = 12'hFFF;
    settle();
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);

    // R7 disable group, R10 otherwise
    out_dis_n = 1'b0;
    @(negedge clk);
    chk("R7 group off", {4'b0, pin_oe}, 16'h083F);
    out_dis_n = 1'b1;
    @(negedge clk);
    chk("R10 oe follows dir", {4'b0, pin_oe}, 16'h0FFF);

    // R8 standby clears and blocks
    access(1'b1, 1'b1, REG, 16'h3F3F, 1'b1);
    hw_standby = 1'b1;
    @(negedge clk);
    chk("R8 cleared", {4'b0, pin_out}, 16'h0);
    model = '0;
    access(1'b1, 1'b1, REG, 16'hFFFF, 1'b0);
    chk("R8 blocked write", {4'b0, pin_out}, 16'h0);
    hw_standby = 1'b0;
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);

    // R9 watchdog keeps data
    access(1'b1, 1'b1, REG, 16'h1234, 1'b1);
    held = pin_out;
    wdt_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 held during", {4'b0, pin_out}, {4'b0, held});
    wdt_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 held after", {4'b0, pin_out}, {4'b0, model});
    access(1'b0, 1'b1, REG, 16'h0, 1'b1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic wr, sz, miss;
      logic [7:0] a;
      pin_dir   = 12'($urandom);
      pin_in    = 12'($urandom);
      out_dis_n = 1'($urandom);
      settle();
      wr   = 1'($urandom);
      sz   = 1'($urandom);
      miss = ($urandom % 8) == 0;
      a    = miss ? (REG ^ 8'h20) : (REG | 8'(1'($urandom)));
      access(wr, sz, a, 16'($urandom), !miss);
      chk("R5 pin_out", {4'b0, pin_out}, {4'b0, model});
      chk("R7/R10 pin_oe", {4'b0, pin_oe}, {4'b0, exp_oe(pin_dir, out_dis_n)});
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule